// File: doc/BRIEF.md
# Strobe-Driven Word Programming Slave

This block is the device-side half of a word programming link. An external master shares one 16-bit port bus with it and moves work across by two active-low strobes. One strobe marks an address-and-command phase. The other marks a data phase. During a data phase the slave writes the bus word into a word array, or it returns the stored word on the bus. All strobe inputs pass through a two-flop synchronizer before the core logic acts on them.

After every write the slave reads the word back and raises a per-word pass flag if it matches. A second flag stays high only while every write since programming mode was entered has matched. A third strobe advances the held address by one word. This lets runs of words be written or read back without new address phases. Programming mode is entered a fixed number of clock cycles after reset is released.

The array is a register-file model. It has a fault hook that corrupts the writes to one chosen address, so that the failure paths can be exercised.

Top module: `slvprog_ctrl`

## Requirements
- R1: After reset the per-word flag `word_ok` is 0, the cumulative flag `all_ok` is 1 and `bus_oe` is 0. The held address is 0 and the held command is dump.
- R2: A falling edge of `addr_stb_n` latches the command from `bus_in[0]` and the word address from `bus_in[15:1]`. A command value of 1 means write and 0 means dump.
- R3: A falling edge of `data_stb_n` with the write command stores `bus_in` at the held address, and the bus is not driven during it.
- R4: Each falling edge of `data_stb_n` clears `word_ok`. After a write, `word_ok` rises only if the word read back equals the word written. A dump leaves it at 0.
- R5: `all_ok` falls on the first failed verify and stays low until the next reset.
- R6: A falling edge of `inc_n` adds one to the held address, wrapping from 0x7FFF to 0. The following data phases then use the new address without an address phase.
- R7: All three strobes are ignored for HOLDOFF (default 1100) clock cycles after reset is released.
- R8: With the dump command, `bus_oe` rises and `bus_out` carries the stored word no more than 4 clock cycles after `data_stb_n` falls. This is well inside a 50-cycle bound.
- R9: `bus_oe` falls no more than 4 clock cycles after `data_stb_n` rises. It is low whenever no dump is in progress.
- R10: While `inj_en` is 1, a write to `inj_addr` stores `bus_in ^ inj_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, the oscillator reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 16 | Port bus as driven by the master |
| bus_out | output | 16 | Word returned in a dump |
| bus_oe | output | 1 | Slave drives the bus when 1 |
| addr_stb_n | input | 1 | Address/command strobe, active low |
| data_stb_n | input | 1 | Data strobe, active low |
| inc_n | input | 1 | Address advance strobe, active low |
| inj_en | input | 1 | Enables the array fault |
| inj_addr | input | 15 | Word address that the fault corrupts |
| inj_mask | input | 16 | Bits flipped by the fault |
| word_ok | output | 1 | Last write verified |
| all_ok | output | 1 | Every write since entry verified |

## Verification
Random addresses and random data words are written and then dumped back. Each pair shows whether the address and command are latched on the right strobe and whether the data path is in place. A full readback of every written address at the end detects writes that landed at the wrong address. Directed runs cover several other cases:
- Runs driven only by the advance strobe, with one crossing the 0x7FFF wrap, separate auto-increment from explicit addressing.
- An address phase issued during the hold-off window would turn the next data phase into a write. Watching for a driven bus in that phase shows whether the window was honoured.
- A write to the faulted address, followed by a clean write, separates the per-word flag from the sticky cumulative flag.
- A second reset shows that the cumulative flag and the address return to their entry values.

// File: rtl/slvprog_pkg.sv
package slvprog_pkg;
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_VERIFY = 2'd1,
    PS_DUMP   = 2'd2
  } ps_state_e;
endpackage

// File: rtl/slvprog_edge.sv
// Two-flop synchronizer plus edge detection for active-low strobes.
module slvprog_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : gen_sync
    logic [2:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= 3'b111;
      else        sh_q <= {sh_q[1:0], in_n[g]};
    end
    assign fall[g] = sh_q[2] & ~sh_q[1];
    assign rise[g] = ~sh_q[2] & sh_q[1];
  end
endmodule

// File: rtl/slvprog_array.sv
// Register-file model of the word array with a write-corruption hook.
module slvprog_array #(
  parameter int DW    = 16,
  parameter int AW    = 15,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          inj_en,
  input  logic [AW-1:0] inj_addr,
  input  logic [DW-1:0] inj_mask,
  output logic [DW-1:0] rdata
);
  logic [DEPTH*DW-1:0] flat;
  logic [DW-1:0]       wval;

  assign wval = (inj_en && (addr == inj_addr)) ? (wdata ^ inj_mask) : wdata;

  for (genvar i = 0; i < DEPTH; i++) begin : gen_word
    localparam logic [AW-1:0] MY_ADDR = AW'(i);
    logic          hit;
    logic [DW-1:0] q;
    assign hit = we && (addr == MY_ADDR);
    always_ff @(posedge clk) begin
      if (hit) q <= wval;
    end
    assign flat[i*DW +: DW] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (addr == AW'(i)) rdata = flat[i*DW +: DW];
    end
  end
endmodule

// File: rtl/slvprog_ctrl.sv
module slvprog_ctrl #(
  parameter int DW      = 16,
  parameter int DEPTH   = 64,
  parameter int HOLDOFF = 1100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic          addr_stb_n,
  input  logic          data_stb_n,
  input  logic          inc_n,
  input  logic          inj_en,
  input  logic [DW-2:0] inj_addr,
  input  logic [DW-1:0] inj_mask,
  output logic          word_ok,
  output logic          all_ok
);
  import slvprog_pkg::*;

  localparam int AW = DW - 1;
  localparam int CW = $clog2(HOLDOFF + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLDOFF);

  // strobe index: 0 address, 1 data, 2 advance
  logic [2:0] fall, rise;
  slvprog_edge #(.N(3)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .in_n ({inc_n, data_stb_n, addr_stb_n}),
    .fall (fall),
    .rise (rise)
  );

  logic [CW-1:0] hold_q;
  logic          ready_q;
  logic [AW-1:0] addr_q, addr_d;
  logic          cmd_q, cmd_d;
  logic [DW-1:0] data_q, data_d;
  logic [DW-1:0] out_q, out_d;
  logic          oe_q, oe_d;
  logic          pver_q, pver_d;
  logic          cpver_q, cpver_d;
  ps_state_e     st_q, st_d;
  logic          we;
  logic [DW-1:0] rdata;

  slvprog_array #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .we      (we),
    .addr    (addr_q),
    .wdata   (bus_in),
    .inj_en  (inj_en),
    .inj_addr(inj_addr),
    .inj_mask(inj_mask),
    .rdata   (rdata)
  );

  // hold-off window before programming mode
  logic hold_en;
  assign hold_en = !ready_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      ready_q <= 1'b0;
    end else if (hold_en) begin
      if (hold_q == HOLD_LAST - CW'(1)) ready_q <= 1'b1;
      hold_q <= hold_q + CW'(1);
    end
  end

  always_comb begin
    addr_d  = addr_q;
    cmd_d   = cmd_q;
    data_d  = data_q;
    out_d   = out_q;
    oe_d    = oe_q;
    pver_d  = pver_q;
    cpver_d = cpver_q;
    st_d    = st_q;
    we      = 1'b0;
    unique case (st_q)
      PS_IDLE: begin
        if (ready_q) begin
          if (fall[0]) begin
            addr_d = bus_in[DW-1:1];
            cmd_d  = bus_in[0];
          end else if (fall[2]) begin
            addr_d = addr_q + AW'(1);
          end
          if (fall[1]) begin
            data_d = bus_in;
            pver_d = 1'b0;
            if (cmd_q) begin
              we   = 1'b1;
              st_d = PS_VERIFY;
            end else begin
              out_d = rdata;
              oe_d  = 1'b1;
              st_d  = PS_DUMP;
            end
          end
        end
      end
      PS_VERIFY: begin
        pver_d  = (rdata == data_q);
        cpver_d = cpver_q & (rdata == data_q);
        st_d    = PS_IDLE;
      end
      PS_DUMP: begin
        if (rise[1]) begin
          oe_d = 1'b0;
          st_d = PS_IDLE;
        end
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cmd_q   <= 1'b0;
      data_q  <= '0;
      out_q   <= '0;
      oe_q    <= 1'b0;
      pver_q  <= 1'b0;
      cpver_q <= 1'b1;
      st_q    <= PS_IDLE;
    end else begin
      addr_q  <= addr_d;
      cmd_q   <= cmd_d;
      data_q  <= data_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
      pver_q  <= pver_d;
      cpver_q <= cpver_d;
      st_q    <= st_d;
    end
  end

  assign bus_out = oe_q ? out_q : '0;
  assign bus_oe  = oe_q;
  assign word_ok = pver_q;
  assign all_ok  = cpver_q;
endmodule

// File: rtl/slvprog_chk.sv
module slvprog_chk #(
  parameter int DW      = 16,
  parameter int HOLDOFF = 1100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          data_stb_n,
  input logic          bus_oe,
  input logic          word_ok,
  input logic          all_ok,
  input logic          ready_q,
  input logic          cmd_q,
  input logic [DW-2:0] addr_q
);
  localparam int CW = $clog2(HOLDOFF + 1);
  logic [CW-1:0] since_q;
  logic [5:0]    lo_q;
  logic [3:0]    hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      if (since_q != CW'(HOLDOFF)) since_q <= since_q + CW'(1);
      lo_q <= data_stb_n ? 6'd0 : ((lo_q == 6'd63) ? lo_q : lo_q + 6'd1);
      hi_q <= !data_stb_n ? 4'd0 : ((hi_q == 4'd15) ? hi_q : hi_q + 4'd1);
    end
  end

  p_holdoff_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q < CW'(HOLDOFF)) |-> (addr_q == '0));
  p_dump_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q >= 6'd50 && !cmd_q && ready_q) |-> bus_oe);
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q >= 4'd4) |-> !bus_oe);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !all_ok |=> !all_ok);
  p_fail_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(all_ok) |-> !word_ok);
endmodule

bind slvprog_ctrl slvprog_chk #(.DW(DW), .HOLDOFF(HOLDOFF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .data_stb_n(data_stb_n),
  .bus_oe    (bus_oe),
  .word_ok   (word_ok),
  .all_ok    (all_ok),
  .ready_q   (ready_q),
  .cmd_q     (cmd_q),
  .addr_q    (addr_q)
);

// File: tb/tb_slvprog_ctrl.sv
module tb_slvprog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLDOFF    = 1100;
  localparam int DEPTH      = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_in, bus_out, inj_mask;
  logic        bus_oe, addr_stb_n, data_stb_n, inc_n, inj_en, word_ok, all_ok;
  logic [14:0] inj_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [15:0] ref_mem [DEPTH];
  bit          ref_ok  [DEPTH];
  logic [14:0] cur_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  slvprog_ctrl #(.DW(16), .DEPTH(DEPTH), .HOLDOFF(HOLDOFF)) dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n), .inc_n(inc_n),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask),
    .word_ok(word_ok), .all_ok(all_ok)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stored_val(input logic [14:0] a, input logic [15:0] d);
    return (inj_en && a == inj_addr) ? (d ^ inj_mask) : d;
  endfunction

  task automatic pale(input logic [14:0] a, input bit w);
    bus_in = {a, w};
    addr_stb_n = 1'b0; tick(6);
    addr_stb_n = 1'b1; tick(6);
  endtask

  task automatic inc();
    inc_n = 1'b0; tick(6);
    inc_n = 1'b1; tick(6);
    cur_addr = cur_addr + 15'd1;
  endtask

  // one data phase; returns what was seen on the bus while the strobe was low
  task automatic prog(input logic [15:0] d, output logic [15:0] s_out, output logic s_oe,
                      output logic rel_oe);
    bus_in = d;
    data_stb_n = 1'b0; tick(6);
    s_out = bus_out; s_oe = bus_oe;
    data_stb_n = 1'b1; tick(5);
    rel_oe = bus_oe;
    tick(1);
  endtask

  task automatic write_word(input logic [14:0] a, input logic [15:0] d, input string req);
    logic [15:0] so; logic soe, roe, exp_ok;
    pale(a, 1'b1);
    cur_addr = a;
    prog(d, so, soe, roe);
    exp_ok = (stored_val(a, d) == d);
    ref_mem[a[5:0]] = stored_val(a, d);
    ref_ok[a[5:0]]  = 1'b1;
    chk({req, " R3 no drive on write"}, {15'd0, soe}, 16'd0);
    chk({req, " R4 word_ok"}, {15'd0, word_ok}, {15'd0, exp_ok});
  endtask

  task automatic dump_here(input string req);
    logic [15:0] so; logic soe, roe;
    prog(16'hDEAD, so, soe, roe);
    chk({req, " R8 oe"}, {15'd0, soe}, 16'd1);
    chk({req, " R8 data"}, so, ref_mem[cur_addr[5:0]]);
    chk({req, " R9 release"}, {15'd0, roe}, 16'd0);
    chk({req, " R4 cleared by dump"}, {15'd0, word_ok}, 16'd0);
  endtask

  initial begin
    tick(150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] so, d; logic soe, roe; logic [14:0] a;
    void'($urandom(32'd4711));
    rst_n = 1'b0; bus_in = '0; addr_stb_n = 1'b1; data_stb_n = 1'b1; inc_n = 1'b1;
    inj_en = 1'b0; inj_addr = '0; inj_mask = '0; cur_addr = '0;
    for (int i = 0; i < DEPTH; i++) ref_ok[i] = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 all_ok", {15'd0, all_ok}, 16'd1);
    chk("R1 word_ok", {15'd0, word_ok}, 16'd0);
    chk("R1 bus_oe", {15'd0, bus_oe}, 16'd0);

    // R7: write-command address phase during hold-off must be ignored
    pale(15'd5, 1'b1);
    tick(HOLDOFF + 20);
    prog(16'h0F0F, so, soe, roe);
    chk("R7 ignored strobe leaves dump command", {15'd0, soe}, 16'd1);

    write_word(15'd0, 16'h1234, "dir");
    pale(15'd0, 1'b0); cur_addr = 15'd0;
    dump_here("dir R2");

    // random write / dump pairs
    for (int i = 0; i < 40; i++) begin
      a = 15'($urandom % DEPTH);
      d = 16'($urandom);
      write_word(a, d, "rnd");
      chk("rnd R5 all_ok", {15'd0, all_ok}, 16'd1);
      pale(a, 1'b0); cur_addr = a;
      dump_here("rnd R2");
    end

    // R6: auto-increment write then readback
    pale(15'd40, 1'b1); cur_addr = 15'd40;
    for (int k = 0; k < 4; k++) begin
      d = 16'($urandom);
      prog(d, so, soe, roe);
      ref_mem[cur_addr[5:0]] = d; ref_ok[cur_addr[5:0]] = 1'b1;
      chk("R6 inc write ok", {15'd0, word_ok}, 16'd1);
      inc();
    end
    pale(15'd40, 1'b0); cur_addr = 15'd40;
    for (int k = 0; k < 4; k++) begin
      dump_here("R6 inc readback");
      inc();
    end

    // R6 wrap
    pale(15'h7FFF, 1'b0); cur_addr = 15'h7FFF;
    inc();
    chk("R6 wrap addr", {1'b0, cur_addr}, 16'd0);
    dump_here("R6 wrap");

    // R10 / R5 fault path
    inj_en = 1'b1; inj_addr = 15'd20; inj_mask = 16'h0010;
    write_word(15'd20, 16'h00FF, "R10 fault");
    chk("R5 all_ok falls", {15'd0, all_ok}, 16'd0);
    pale(15'd20, 1'b0); cur_addr = 15'd20;
    dump_here("R10 corrupted word");
    chk("R10 stored value", ref_mem[20], 16'h00EF);
    write_word(15'd21, 16'h5A5A, "R5 clean after fail");
    chk("R5 stays low", {15'd0, all_ok}, 16'd0);

    // full readback of everything written
    for (int i = 0; i < DEPTH; i++) begin
      if (ref_ok[i]) begin
        pale(15'(i), 1'b0); cur_addr = 15'(i);
        dump_here("final R3");
      end
    end

    // re-entry: flag and address back to entry values
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(1);
    chk("R1 re-entry all_ok", {15'd0, all_ok}, 16'd1);
    tick(HOLDOFF + 20);
    cur_addr = 15'd0;
    dump_here("R1 address zero");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule